// File: doc/BRIEF.md
# Quad DAC Serial Command Transmitter

This block drives the three-wire write port of a four-channel 8-bit DAC from the host side, plus a separate output-update strobe. A command arrives on a valid/ready handshake. It carries a 2-bit channel number, a gain-select bit, an 8-bit code and an update-now flag. The block captures the command, shifts an 11-bit word out on a serial clock and data pair, and pulses the frame-latch line low. If the update flag was set, it then pulses the output-update line low.

Serial timing comes from the system clock. Each serial clock phase, and each half of a strobe, lasts `HALF_DIV` system clocks (minimum 1). The device samples data on the falling serial clock edge, so data moves only at the rising edge. The controller is a Moore state machine with these states:

- `ST_IDLE`: waits for a command. Taking a command moves it to `ST_BIT_HI`.
- `ST_BIT_HI`: the serial clock is high for one phase, then the machine moves to `ST_BIT_LO`.
- `ST_BIT_LO`: the serial clock is low for one phase. The machine returns to `ST_BIT_HI` and shifts the next bit out. After the last bit it moves to `ST_LATCH_A` instead.
- `ST_LATCH_A` and `ST_LATCH_B`: the two halves of the frame-latch low pulse. From `ST_LATCH_B` the machine moves to `ST_GAP` if an update was requested, and otherwise to `ST_IDLE`.
- `ST_GAP`: one phase with both strobes high. It then moves to `ST_UPD_A`.
- `ST_UPD_A` and `ST_UPD_B`: the two halves of the update low pulse. The machine then returns to `ST_IDLE`.

Top module: `qdac_cmd_tx`

## Requirements
- R1: After reset, `ser_clk`, `latch_n` and `update_n` are high, `cmd_ready` is 1 and `busy` is 0.
- R2: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. From that edge, `busy` is 1 and `cmd_ready` is 0 until the last strobe of the transfer returns high. `cmd_ready` is never 1 while any output line is low.
- R3: The word is 11 bits, sent most significant bit first. Word bits 10..9 hold the channel, bit 8 holds the gain bit and bits 7..0 hold the code. All fields are captured at acceptance, so input changes after that point have no effect.
- R4: `ser_data` changes only while `ser_clk` is high, or on the edge where `ser_clk` rises. It holds its value through every low phase and at every falling edge.
- R5: Each high and each low phase of `ser_clk` during the word lasts `HALF_DIV` system clocks. A transfer has exactly 11 falling edges.
- R6: `latch_n` falls on the edge that ends the eleventh low phase. It stays low for 2*`HALF_DIV` clocks and falls exactly once per transfer.
- R7: If the update flag was set, `update_n` falls once, `HALF_DIV` clocks after `latch_n` returns high, and stays low for 2*`HALF_DIV` clocks. If the flag was clear, `update_n` stays high.
- R8: `cmd_ready` returns to 1 on the edge where the last strobe rises. That is `update_n` when an update was requested, and `latch_n` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_chan | input | 2 | DAC channel number |
| cmd_gain | input | 1 | Gain-select bit |
| cmd_code | input | 8 | DAC code |
| cmd_update | input | 1 | Pulse the update line after the latch |
| ser_clk | output | 1 | Serial clock, high when idle |
| ser_data | output | 1 | Serial data, MSB first |
| latch_n | output | 1 | Frame latch strobe, active low |
| update_n | output | 1 | Output update strobe, active low |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench sweeps every channel, both gain values and both update settings against all-zero, all-one and alternating codes. It scrambles the command inputs right after acceptance, so a design that samples its fields late would shift out the wrong word. A passive monitor decodes the word on falling serial edges, in the same way the device does. It flags any data change during a low phase, which catches a design that shifts on the falling edge. It also measures every phase and pulse width, which exposes off-by-one errors in the divider, a latch pulse one phase short, a missing gap before the update strobe, and a ready that returns at the wrong strobe.

// File: rtl/qdac_tx_pkg.sv
package qdac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_HI,
        ST_BIT_LO,
        ST_LATCH_A,
        ST_LATCH_B,
        ST_GAP,
        ST_UPD_A,
        ST_UPD_B
    } tx_state_e;

endpackage

// File: rtl/qdac_tick_gen.sv
module qdac_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R5

endmodule

// File: rtl/qdac_frame_shreg.sv
module qdac_frame_shreg #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               shift_i,
    output logic               msb_o,
    output logic               last_o
);
    localparam int NW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] word_q;
    logic [NW-1:0]      left_q;

    assign msb_o  = word_q[FRAME_W-1];
    assign last_o = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            left_q <= NW'(FRAME_W - 1);
        end else if (shift_i) begin
            word_q <= {word_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o);  // R5
    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));  // R3

endmodule

// File: rtl/qdac_cmd_tx.sv
module qdac_cmd_tx
    import qdac_tx_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CHAN_W   = 2,
    parameter int CODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              cmd_gain,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_update,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              latch_n,
    output logic              update_n,
    output logic              busy
);
    localparam int FRAME_W = CHAN_W + 1 + CODE_W;

    tx_state_e state_q, state_d;
    logic      tick, last_bit, accept, shift, upd_q;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign shift     = (state_q == ST_BIT_LO) && tick && !last_bit;

    qdac_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != ST_IDLE),
        .tick_o (tick)
    );

    qdac_frame_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .word_i  ({cmd_chan, cmd_gain, cmd_code}),
        .shift_i (shift),
        .msb_o   (ser_data),
        .last_o  (last_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else if (accept)
            upd_q <= cmd_update;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_BIT_HI;
            ST_BIT_HI:  if (tick)   state_d = ST_BIT_LO;
            ST_BIT_LO:  if (tick)   state_d = last_bit ? ST_LATCH_A : ST_BIT_HI;
            ST_LATCH_A: if (tick)   state_d = ST_LATCH_B;
            ST_LATCH_B: if (tick)   state_d = upd_q ? ST_GAP : ST_IDLE;
            ST_GAP:     if (tick)   state_d = ST_UPD_A;
            ST_UPD_A:   if (tick)   state_d = ST_UPD_B;
            ST_UPD_B:   if (tick)   state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk  <= 1'b1;
            latch_n  <= 1'b1;
            update_n <= 1'b1;
            busy     <= 1'b0;
        end else begin
            ser_clk  <= (state_d != ST_BIT_LO);
            latch_n  <= !((state_d == ST_LATCH_A) || (state_d == ST_LATCH_B));
            update_n <= !((state_d == ST_UPD_A) || (state_d == ST_UPD_B));
            busy     <= (state_d != ST_IDLE);
        end
    end

    AST_READY_LOW_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_n || !update_n || !ser_clk) |-> !cmd_ready);  // R2
    AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));  // R2
    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && $past(!ser_clk)) |-> $stable(ser_data));  // R4
    AST_UPDATE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(update_n) |-> (latch_n && $past(latch_n)));  // R7

endmodule

// File: tb/qdac_cmd_tx_test.sv
module qdac_cmd_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int H  = 2;
    localparam int FW = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_chan = '0;
    logic       cmd_gain = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       cmd_update = 1'b0;
    logic       cmd_ready, ser_clk, ser_data, latch_n, update_n, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_cmd_tx #(.HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_chan(cmd_chan), .cmd_gain(cmd_gain), .cmd_code(cmd_code),
        .cmd_update(cmd_update), .ser_clk(ser_clk), .ser_data(ser_data),
        .latch_n(latch_n), .update_n(update_n), .busy(busy)
    );

    int n_checks = 0, n_errs = 0;
    int mon_checks = 0, mon_errs = 0;
    logic exp_upd = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        mon_checks++;
        if (!ok) begin
            mon_errs++;
            $display("FAIL %s (monitor): actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // passive monitor, samples at the falling system clock edge
    logic [FW-1:0] cap = '0;
    int nfall = 0, nload = 0, nupd = 0;
    int run = 0, lrun = 0, urun = 0;
    bit rise_seen = 0;
    logic p_sclk = 1, p_data = 0, p_load = 1, p_upd = 1, p_busy = 0, p_ready = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !p_busy) begin
                cap = '0; nfall = 0; nload = 0; nupd = 0; rise_seen = 0;
            end
            if (!ser_clk && !p_sclk && ser_data != p_data)
                mchk(0, "R4 data moved while clock low", int'(ser_data), int'(p_data));
            if (p_sclk && !ser_clk) begin
                cap = {cap[FW-2:0], ser_data};
                nfall++;
                if (rise_seen) mchk(run == H, "R5 high phase", run, H);
            end
            if (!p_sclk && ser_clk) begin
                rise_seen = 1;
                mchk(run == H, "R5 low phase", run, H);
            end
            if (p_load && !latch_n) begin
                nload++;
                mchk(nfall == FW, "R6 latch after eleventh bit", nfall, FW);
            end
            if (!p_load && latch_n)
                mchk(lrun == 2*H, "R6 latch width", lrun, 2*H);
            if (p_upd && !update_n) begin
                nupd++;
                mchk(latch_n && nload == 1, "R7 update after latch", nload, 1);
                mchk(lrun == H, "R7 gap before update", lrun, H);
            end
            if (!p_upd && update_n)
                mchk(urun == 2*H, "R7 update width", urun, 2*H);
            mchk(cmd_ready == !busy, "R2 ready vs busy", int'(cmd_ready), int'(!busy));
            if (!latch_n || !update_n || !ser_clk)
                mchk(!cmd_ready, "R2 ready during strobe", int'(cmd_ready), 0);
            if (cmd_ready && !p_ready)
                mchk(exp_upd ? (update_n && !p_upd) : (latch_n && !p_load),
                     "R8 ready on last strobe", int'(exp_upd), int'(exp_upd));
            run  = (ser_clk == p_sclk) ? run + 1 : 1;
            lrun = (latch_n == p_load) ? lrun + 1 : 1;
            urun = (update_n == p_upd) ? urun + 1 : 1;
        end
        p_sclk = ser_clk; p_data = ser_data; p_load = latch_n;
        p_upd = update_n; p_busy = busy; p_ready = cmd_ready;
    end

    task automatic report(input int extra);
        $display("Simulation finished: %0d checks, %0d errors",
                 n_checks + mon_checks + extra, n_errs + mon_errs + extra);
        $finish;
    endtask

    task automatic run_frame(input logic [1:0] ch, input logic g,
                             input logic [7:0] v, input logic u);
        logic [FW-1:0] exp_w;
        exp_w = {ch, g, v};
        @(negedge clk); #1;
        exp_upd = u;
        cmd_chan = ch; cmd_gain = g; cmd_code = v; cmd_update = u; cmd_valid = 1'b1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        chk(busy && !cmd_ready, "R2 busy after accept", int'(busy), 1);
        cmd_valid = 1'b0;
        cmd_chan = ~ch; cmd_gain = ~g; cmd_code = ~v; cmd_update = ~u;
        while (!cmd_ready) begin @(negedge clk); #1; end
        chk(cap == exp_w, "R3 word", int'(cap), int'(exp_w));
        chk(nfall == FW, "R5 falling edges", nfall, FW);
        chk(nload == 1, "R6 latch pulses", nload, 1);
        chk(nupd == int'(u), "R7 update pulses", nupd, int'(u));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        report(1);
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(ser_clk && latch_n && update_n, "R1 strobes idle high", int'({ser_clk, latch_n, update_n}), 7);
        chk(cmd_ready && !busy, "R1 ready after reset", int'({cmd_ready, busy}), 2);
        rst_n = 1'b1;
        for (int ch = 0; ch < 4; ch++)
            for (int g = 0; g < 2; g++)
                for (int u = 0; u < 2; u++)
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] v;
                        case (k)
                            0: v = 8'h00;
                            1: v = 8'hFF;
                            2: v = 8'hA5;
                            default: v = 8'h5A ^ 8'(ch);
                        endcase
                        run_frame(2'(ch), 1'(g), v, 1'(u));
                    end
        repeat (5) @(negedge clk);
        #1;
        chk(ser_clk && latch_n && update_n && !busy, "R1 idle after sweep",
            int'({ser_clk, latch_n, update_n, busy}), 14);
        report(0);
    end

endmodule